// File: doc/BRIEF.md
# Serial Peripheral Register Guard with Stop Control

This block is the register front end of a serial multiplexing peripheral. It holds a small module configuration register, a transfer control register, two transfer configuration words and a set of general data words. Every bus request passes through a legality check before any state changes. The check looks at the current stop state, the privilege level of the request and the transfer enables. A legal request gets a one-cycle acknowledge. An illegal one gets a one-cycle bus-error strobe instead, and no register changes.

The configuration register carries a stop request and a privilege-space selector. While stop is set, the block deasserts the clock-enable that gates the rest of the peripheral. Stop can be entered only from an idle control state: transmit, receive and continuous operation must all be off. While stopped, only the configuration register can be reached. Software therefore leaves stop mode by writing that register.

The control register also drives the transmit, receive, continuous and start-transfer lines towards the serial datapath. That datapath is not part of this block. Its only feedback is a frame-done pulse, which clears the start bit.

Top module: `smux_ctrl_guard`

## Requirements
- R1: After reset all registers read 0 and clk_en is 1. rsp_ack and rsp_err are 0 while no request is pending. A user-mode read of a data word (addresses 4 to 7) is acknowledged with data 0.
- R2: Each request sampled with req_valid=1 is answered in the next cycle by exactly one of rsp_ack or rsp_err, each lasting one cycle. A cycle without a request gives neither.
- R3: The address map is as follows. Address 0 is configuration: bit 0 is stop, bit 1 is supervisor-only. Address 1 is control: bit 0 transmit, bit 1 receive, bit 2 continuous, bit 3 start. Address 2 is the transmit configuration word and address 3 the receive configuration word. Addresses 4 to 7 are data words. Words at addresses 2 to 7 store all DATA_W bits. Unused bits of addresses 0 and 1 read 0. Read data appears on rsp_rdata with the acknowledge, and rsp_rdata is 0 otherwise.
- R4: A configuration write with bit 0 set is refused with rsp_err while transmit, receive or continuous is 1.
- R5: clk_en is 0 exactly while the stop bit is 1, and it changes in the same cycle as the stop bit.
- R6: While stop is 1, any access to addresses 1 to 7 gives rsp_err. The configuration register stays accessible, so writing 0 to its bit 0 leaves stop.
- R7: With the supervisor-only bit 0, a user-mode access (req_super=0) to address 0, 2 or 3 gives rsp_err. Addresses 1 and 4 to 7 accept user-mode access.
- R8: With the supervisor-only bit 1, every user-mode access gives rsp_err.
- R9: A refused access changes no register, and its rsp_rdata is 0.
- R10: A frame_done pulse clears the start bit. A legal control write in the same cycle takes precedence, so its bit 3 value is kept.
- R11: tx_en, rx_en, cont_mode and xfer_start follow the control register bits one cycle after the write or clear that changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_super | input | 1 | 1 supervisor-mode request, 0 user-mode |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| frame_done | input | 1 | Pulse from the serial datapath at the end of a frame |
| rsp_ack | output | 1 | Request accepted (one cycle) |
| rsp_err | output | 1 | Request refused, bus error (one cycle) |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_ack |
| clk_en | output | 1 | Clock enable for the rest of the peripheral |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| cont_mode | output | 1 | Continuous transfer mode |
| xfer_start | output | 1 | Start-transfer flag |

## Verification
The bench goes after the stop-entry guard from each busy source on its own: transmit alone, receive alone and continuous alone. A guard that tested only the enables would let stop in under continuous mode and drop clk_en. It then checks that control and data words are unreachable while stopped, while the configuration word still answers. A decoder that blocked everything could never leave stop, and one that blocked nothing would let the enables be changed with clocks off. It covers both privilege settings across all addresses, and it holds a start write against a coincident frame_done. Getting that priority wrong would lose a start request. Random traffic with frequent illegal requests then confirms that no refused write leaves a trace in a later read.

// File: rtl/smux_guard_pkg.sv
package smux_guard_pkg;
  localparam int CFG_ADDR    = 0;
  localparam int CTRL_ADDR   = 1;
  localparam int TXCFG_ADDR  = 2;
  localparam int RXCFG_ADDR  = 3;
  localparam int FIRST_WORD  = 2;

  localparam int CFG_STOP    = 0;
  localparam int CFG_SUP     = 1;
  localparam int CTRL_TX     = 0;
  localparam int CTRL_RX     = 1;
  localparam int CTRL_CONT   = 2;
  localparam int CTRL_START  = 3;

  typedef enum logic [1:0] {
    DENY_NONE    = 2'd0,
    DENY_STOPPED = 2'd1,
    DENY_PRIV    = 2'd2,
    DENY_BUSY    = 2'd3
  } deny_e;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_SMALL = 2'd1,
    RD_MEM   = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/smux_access_check.sv
module smux_access_check
  import smux_guard_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              write_i,
  input  logic              super_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              set_stop_i,
  input  logic              stop_i,
  input  logic              sup_only_i,
  input  logic              busy_i,
  output logic              deny_o
);
  deny_e cause;
  logic  restricted;
  logic  is_cfg;

  always_comb begin
    is_cfg     = (addr_i == ADDR_W'(CFG_ADDR));
    restricted = sup_only_i || is_cfg ||
                 (addr_i == ADDR_W'(TXCFG_ADDR)) ||
                 (addr_i == ADDR_W'(RXCFG_ADDR));
    if (stop_i && !is_cfg)
      cause = DENY_STOPPED;
    else if (restricted && !super_i)
      cause = DENY_PRIV;
    else if (write_i && is_cfg && set_stop_i && busy_i)
      cause = DENY_BUSY;
    else
      cause = DENY_NONE;
    deny_o = (cause != DENY_NONE);
  end
endmodule

// File: rtl/smux_ctrl_regs.sv
module smux_ctrl_regs
  import smux_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we_i,
  input  logic       ctrl_we_i,
  input  logic [3:0] wbits_i,
  input  logic       frame_done_i,
  output logic       stop_o,
  output logic       sup_only_o,
  output logic       tx_o,
  output logic       rx_o,
  output logic       cont_o,
  output logic       start_o,
  output logic       clk_en_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stop_o     <= 1'b0;
      sup_only_o <= 1'b0;
      tx_o       <= 1'b0;
      rx_o       <= 1'b0;
      cont_o     <= 1'b0;
      start_o    <= 1'b0;
      clk_en_o   <= 1'b1;
    end else begin
      if (cfg_we_i) begin
        stop_o     <= wbits_i[CFG_STOP];
        sup_only_o <= wbits_i[CFG_SUP];
        clk_en_o   <= !wbits_i[CFG_STOP];
      end
      if (ctrl_we_i) begin
        tx_o    <= wbits_i[CTRL_TX];
        rx_o    <= wbits_i[CTRL_RX];
        cont_o  <= wbits_i[CTRL_CONT];
        start_o <= wbits_i[CTRL_START];
      end else if (frame_done_i) begin
        start_o <= 1'b0;
      end
    end
  end

  // R4: stop only ever rises out of an idle control state
  assert_stop_from_idle_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_o) |-> $past(!tx_o && !rx_o && !cont_o));

  // R5: clocks gated exactly while stopped
  assert_clken_tracks_stop_R5: assert property (@(posedge clk) disable iff (rst)
    clk_en_o != stop_o);

  // R6: control bits frozen while stopped
  assert_ctrl_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> $stable({tx_o, rx_o, cont_o}));

  // R10: start is raised only by a write, dropped only by a write or frame end
  assert_start_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(start_o) |-> $past(ctrl_we_i));
  assert_start_fall_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(start_o) |-> $past(ctrl_we_i || frame_done_i));
endmodule

// File: rtl/smux_reg_bank.sv
module smux_reg_bank
  import smux_guard_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [DATA_W-1:0] mem_rd_q;
  logic              vld_rd_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
    mem_rd_q <= mem[addr_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      vld_rd_q <= 1'b0;
    end else begin
      if (we_i) vld_q[addr_i] <= 1'b1;
      vld_rd_q <= vld_q[addr_i];
    end
  end

  assign rdata_o = vld_rd_q ? mem_rd_q : '0;

  // R3: the word store is written only at word addresses
  assert_word_range_R3: assert property (@(posedge clk) disable iff (rst)
    we_i |-> (int'(addr_i) >= FIRST_WORD));
endmodule

// File: rtl/smux_ctrl_guard.sv
module smux_ctrl_guard
  import smux_guard_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_super,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              frame_done,
  output logic              rsp_ack,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              clk_en,
  output logic              tx_en,
  output logic              rx_en,
  output logic              cont_mode,
  output logic              xfer_start
);
  logic stop_q, sup_q, deny, legal;
  logic cfg_we, ctrl_we, mem_we, is_word;
  logic [DATA_W-1:0] bank_rd, small_d, small_q;
  rd_sel_e sel_d, sel_q;

  smux_access_check #(.ADDR_W(ADDR_W)) u_check (
    .write_i(req_write), .super_i(req_super), .addr_i(req_addr),
    .set_stop_i(req_wdata[CFG_STOP]), .stop_i(stop_q), .sup_only_i(sup_q),
    .busy_i(tx_en || rx_en || cont_mode), .deny_o(deny)
  );

  always_comb begin
    legal   = req_valid && !deny;
    is_word = (int'(req_addr) >= FIRST_WORD);
    cfg_we  = legal && req_write && (req_addr == ADDR_W'(CFG_ADDR));
    ctrl_we = legal && req_write && (req_addr == ADDR_W'(CTRL_ADDR));
    mem_we  = legal && req_write && is_word;
    small_d = '0;
    if (req_addr == ADDR_W'(CFG_ADDR)) begin
      small_d[CFG_STOP] = stop_q;
      small_d[CFG_SUP]  = sup_q;
    end else begin
      small_d[CTRL_TX]    = tx_en;
      small_d[CTRL_RX]    = rx_en;
      small_d[CTRL_CONT]  = cont_mode;
      small_d[CTRL_START] = xfer_start;
    end
    if (!legal || req_write) sel_d = RD_NONE;
    else if (is_word)        sel_d = RD_MEM;
    else                     sel_d = RD_SMALL;
  end

  smux_ctrl_regs u_ctrl (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .ctrl_we_i(ctrl_we),
    .wbits_i(req_wdata[3:0]), .frame_done_i(frame_done),
    .stop_o(stop_q), .sup_only_o(sup_q), .tx_o(tx_en), .rx_o(rx_en),
    .cont_o(cont_mode), .start_o(xfer_start), .clk_en_o(clk_en)
  );

  smux_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .we_i(mem_we), .addr_i(req_addr),
    .wdata_i(req_wdata), .rdata_o(bank_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ack <= 1'b0;
      rsp_err <= 1'b0;
      sel_q   <= RD_NONE;
      small_q <= '0;
    end else begin
      rsp_ack <= legal;
      rsp_err <= req_valid && deny;
      sel_q   <= sel_d;
      small_q <= small_d;
    end
  end

  assign rsp_rdata = (sel_q == RD_MEM)   ? bank_rd :
                     (sel_q == RD_SMALL) ? small_q : '0;

  // R2: one answer per request, never both
  assert_one_answer_R2: assert property (@(posedge clk) disable iff (rst)
    !(rsp_ack && rsp_err));
  assert_answer_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_ack || rsp_err) == $past(req_valid));

  // R6: only the configuration word answers while stopped
  assert_stopped_refuse_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid && stop_q && (req_addr != ADDR_W'(CFG_ADDR)) |=> rsp_err);

  // R7 / R8: user-mode access to a restricted word is refused
  assert_user_refused_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_super &&
    (sup_q || req_addr == ADDR_W'(CFG_ADDR) ||
     req_addr == ADDR_W'(TXCFG_ADDR) || req_addr == ADDR_W'(RXCFG_ADDR))
    |=> rsp_err);

  // R9: no data leaks on a refusal
  assert_err_no_data_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));
endmodule

// File: tb/smux_ctrl_guard_tb_top.sv
`timescale 1ns/1ps
module smux_ctrl_guard_tb_top;
  localparam int AW = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_super = 0, frame_done = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_ack, rsp_err, clk_en, tx_en, rx_en, cont_mode, xfer_start;
  logic [DW-1:0] rsp_rdata;

  always #2 clk = ~clk;

  smux_ctrl_guard #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_super(req_super), .req_addr(req_addr), .req_wdata(req_wdata),
    .frame_done(frame_done), .rsp_ack(rsp_ack), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .clk_en(clk_en), .tx_en(tx_en), .rx_en(rx_en),
    .cont_mode(cont_mode), .xfer_start(xfer_start)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  bit m_stop, m_sup, m_tx, m_rx, m_cont, m_start;
  logic [DW-1:0] m_mem [8];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_deny(bit w, bit s, int a, logic [DW-1:0] d);
    bit restricted;
    if (m_stop && a != 0) return 1;                       // R6
    restricted = m_sup || a == 0 || a == 2 || a == 3;     // R7 R8
    if (restricted && !s) return 1;
    if (w && a == 0 && d[0] && (m_tx || m_rx || m_cont)) return 1;  // R4
    return 0;
  endfunction

  function automatic logic [DW-1:0] exp_read(int a);
    logic [DW-1:0] v = '0;
    if (a == 0) begin v[0] = m_stop; v[1] = m_sup; end
    else if (a == 1) begin v[0] = m_tx; v[1] = m_rx; v[2] = m_cont; v[3] = m_start; end
    else v = m_mem[a];
    return v;
  endfunction

  task automatic access(bit w, bit s, int a, logic [DW-1:0] d, bit fd, string tag);
    bit dn;
    logic [DW-1:0] er;
    @(negedge clk);
    req_valid = 1; req_write = w; req_super = s;
    req_addr = AW'(a); req_wdata = d; frame_done = fd;
    dn = exp_deny(w, s, a, d);
    er = (!dn && !w) ? exp_read(a) : '0;
    if (!dn && w && a == 1) begin
      m_tx = d[0]; m_rx = d[1]; m_cont = d[2]; m_start = d[3];
    end else if (fd) m_start = 0;                          // R10
    if (!dn && w && a == 0) begin m_stop = d[0]; m_sup = d[1]; end
    if (!dn && w && a >= 2) m_mem[a] = d;
    @(negedge clk);
    req_valid = 0; frame_done = 0;
    check({tag, " R2 ack"}, 32'(rsp_ack), 32'(!dn));
    check({tag, " R2 err"}, 32'(rsp_err), 32'(dn));
    check({tag, " R3/R9 rdata"}, 32'(rsp_rdata), 32'(er));
    check({tag, " R5 clk_en"}, 32'(clk_en), 32'(!m_stop));
    check({tag, " R11 ctrl"}, {28'd0, xfer_start, cont_mode, rx_en, tx_en},
          {28'd0, m_start, m_cont, m_rx, m_tx});
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    m_stop = 0; m_sup = 0; m_tx = 0; m_rx = 0; m_cont = 0; m_start = 0;
    for (int i = 0; i < 8; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R1 reset clk_en", 32'(clk_en), 32'd1);
    check("R1 reset idle", {30'd0, rsp_ack, rsp_err}, 32'd0);
    check("R1 reset ctrl", {28'd0, xfer_start, cont_mode, rx_en, tx_en}, 32'd0);
    access(0, 0, 5, '0, 0, "R1 user read word");
    access(0, 1, 0, '0, 0, "R1 read cfg");
    access(0, 1, 3, '0, 0, "R1 read rxcfg");

    access(1, 0, 4, 16'hA5C3, 0, "R3 write word");
    access(0, 0, 4, '0, 0, "R3 readback");
    access(1, 1, 2, 16'hFFFF, 0, "R3 txcfg full width");
    access(0, 1, 2, '0, 0, "R3 txcfg read");
    access(1, 1, 0, 16'hFFFC, 0, "R3 cfg unused bits");
    access(0, 1, 0, '0, 0, "R3 cfg reads zero upper");

    access(1, 0, 0, 16'h0000, 0, "R7 user cfg write");
    access(0, 0, 2, '0, 0, "R7 user txcfg read");
    access(1, 0, 3, 16'h1234, 0, "R7 user rxcfg write");
    access(0, 1, 3, '0, 0, "R9 rxcfg unchanged");
    access(1, 0, 1, 16'h0001, 0, "R7 user ctrl write ok");

    access(1, 1, 0, 16'h0001, 0, "R4 stop with tx");
    access(1, 1, 1, 16'h0002, 0, "R4 only rx");
    access(1, 1, 0, 16'h0001, 0, "R4 stop with rx");
    access(1, 1, 1, 16'h0004, 0, "R4 only cont");
    access(1, 1, 0, 16'h0001, 0, "R4 stop with cont");
    access(0, 1, 0, '0, 0, "R9 cfg unchanged");
    access(1, 1, 1, 16'h0000, 0, "R4 idle ctrl");
    access(1, 1, 0, 16'h0001, 0, "R5 enter stop");
    access(0, 1, 1, '0, 0, "R6 ctrl read stopped");
    access(1, 1, 1, 16'h0001, 0, "R6 ctrl write stopped");
    access(0, 0, 4, '0, 0, "R6 word read stopped");
    access(0, 1, 0, '0, 0, "R6 cfg read stopped");
    access(1, 1, 0, 16'h0000, 0, "R6 leave stop");
    access(0, 1, 1, '0, 0, "R9 ctrl unchanged after stop");

    access(1, 1, 0, 16'h0002, 0, "R8 set sup only");
    access(0, 0, 4, '0, 0, "R8 user word read");
    access(1, 0, 1, 16'h0001, 0, "R8 user ctrl write");
    access(0, 1, 4, '0, 0, "R8 super word read");
    access(1, 1, 0, 16'h0000, 0, "R8 clear sup only");

    access(1, 1, 1, 16'h0008, 0, "R10 set start");
    access(0, 0, 4, '0, 1, "R10 frame done clears");
    access(1, 1, 1, 16'h0008, 1, "R10 write wins");
    access(0, 0, 1, '0, 0, "R10 start kept");
    access(1, 1, 1, 16'h0000, 1, "R10 write clears");

    for (int i = 0; i < 600; i++) begin
      bit w, s, fd;
      int a;
      logic [DW-1:0] d;
      w = 1'($urandom % 2);
      s = ($urandom % 4) != 0;
      a = int'($urandom % 8);
      d = DW'($urandom);
      if (a == 0) d[1] = (($urandom % 4) == 0);
      if (a == 1 && ($urandom % 2) == 1) d[2:0] = 3'b000;
      fd = (($urandom % 4) == 0);
      access(w, s, a, d, fd, "RND");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule